// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds eight ownership tokens that two agents, a left port and a right port, use to reserve shared resources. Each port picks one token by the three lowest bits of its address. Writing 0 on bit 0 of the write data asks for the token, and writing 1 gives it back or withdraws an earlier request. A read returns 0 to the port that holds the token and 1 in every other case, copied onto every bit of that port's read bus.

If a port asks for a token the other side holds, the request is refused but kept. When the holder gives the token back, it passes to the waiting port on the same clock edge. If both ports ask for a free token in the same cycle, the left port gets it and the right port's request waits. Each port's read value is captured in a register when the read is issued and then stays put, so writes that come later cannot change an answer already returned. A semaphore access counts only while the port's semaphore select is high and its memory enable is low. Everything runs on one clock, and a synchronous reset frees every token.

Top module: `sem_token_bank`

## Requirements
- R1: A port's address bits [2:0] select one of eight tokens; the upper address bits have no effect on which token is written or read.
- R2: Write and read strobes of a port act only while its select is 1 and its memory enable is 0; otherwise the tokens and that port's read register are left unchanged.
- R3: On a write only write-data bit 0 matters: 0 requests the token, 1 releases it or withdraws a pending request.
- R4: A read returns 0 to the holding port and 1 to the other port; a free token returns 1 to both. The value is copied to every read-data bit and appears one clock after the edge that takes the read strobe.
- R5: A request from the non-holding port is refused and stored; when the holder releases, ownership moves to the waiting port on that same edge.
- R6: A repeated request by a refused port or by the holder changes nothing; a release by a non-holder cancels that port's stored request.
- R7: The read register changes only on an accepted read of that port, and a read issued in the same cycle as a write returns the state before that write.
- R8: When both ports request a free token in the same cycle, the left port becomes holder and the right port's request is stored.
- R9: Synchronous reset frees all tokens, clears all stored requests and sets both read registers to all ones.
- R10: A holder that releases with no stored request from the other side leaves the token free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_sel | input | 1 | Left semaphore select |
| l_mem_en | input | 1 | Left memory enable; blocks semaphore access when 1 |
| l_addr | input | ADDR_W | Left address; bits [2:0] pick the token |
| l_wr | input | 1 | Left write strobe |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rd | input | 1 | Left read strobe |
| l_rdata | output | DATA_W | Left registered read value |
| r_sem_sel | input | 1 | Right semaphore select |
| r_mem_en | input | 1 | Right memory enable; blocks semaphore access when 1 |
| r_addr | input | ADDR_W | Right address; bits [2:0] pick the token |
| r_wr | input | 1 | Right write strobe |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rd | input | 1 | Right read strobe |
| r_rdata | output | DATA_W | Right registered read value |

## Verification
A write changes token state at the clock edge that samples it, so a read issued in the following cycle already sees the change. A read result is due one edge after its strobe. The driver queues each expected value tagged with that edge's cycle number, and the monitor compares it at the next falling edge. Hold checks for R2 and R7 sample a read bus at the falling edge after a stimulus that must not change it, before any new read is issued on that port.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    owner_e owner;
    logic   l_pend;
    logic   r_pend;
  } tok_t;

  localparam tok_t TOK_IDLE = '{owner: OWN_NONE, l_pend: 1'b0, r_pend: 1'b0};

  // Next state of one token for one clock, given the qualified requests
  // and releases of both ports.
  function automatic tok_t tok_step(input tok_t cur,
                                    input logic l_req, input logic l_rel,
                                    input logic r_req, input logic r_rel);
    tok_t nx;
    logic l_wait;
    logic r_wait;
    nx     = cur;
    l_wait = (cur.l_pend | l_req) & ~l_rel;
    r_wait = (cur.r_pend | r_req) & ~r_rel;
    case (cur.owner)
      OWN_NONE: begin
        nx.l_pend = 1'b0;
        nx.r_pend = 1'b0;
        if (l_req) begin
          nx.owner  = OWN_LEFT;
          nx.r_pend = r_req;
        end else if (r_req) begin
          nx.owner = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        nx.l_pend = 1'b0;
        if (l_rel) begin
          nx.owner  = r_wait ? OWN_RIGHT : OWN_NONE;
          nx.r_pend = 1'b0;
        end else begin
          nx.r_pend = r_wait;
        end
      end
      OWN_RIGHT: begin
        nx.r_pend = 1'b0;
        if (r_rel) begin
          nx.owner  = l_wait ? OWN_LEFT : OWN_NONE;
          nx.l_pend = 1'b0;
        end else begin
          nx.l_pend = l_wait;
        end
      end
      default: nx = TOK_IDLE;
    endcase
    return nx;
  endfunction

  // Value one side sees: 0 only when that side holds the token.
  function automatic logic tok_read(input owner_e o, input logic right_side);
    return (o != (right_side ? OWN_RIGHT : OWN_LEFT));
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              sel,
  input  logic              mem_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_fire,
  output logic              wr_bit,
  output logic              rd_fire
);
  logic active;
  logic unused_bits;

  assign active      = sel & ~mem_en;
  assign idx         = addr[IDX_W-1:0];
  assign wr_fire     = active & wr;
  assign wr_bit      = wdata[0];
  assign rd_fire     = active & rd;
  assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic l_req,
  input  logic l_rel,
  input  logic r_req,
  input  logic r_rel,
  output logic l_val,
  output logic r_val
);
  tok_t st;
  tok_t st_nx;

  // Named events for the checks below.
  logic l_hands_over;
  logic r_hands_over;
  logic tie_on_free;

  assign st_nx = tok_step(st, l_req, l_rel, r_req, r_rel);

  always_ff @(posedge clk) begin
    if (rst) st <= TOK_IDLE;
    else     st <= st_nx;
  end

  assign l_val = tok_read(st.owner, 1'b0);
  assign r_val = tok_read(st.owner, 1'b1);

  assign l_hands_over = (st.owner == OWN_LEFT)  & l_rel & (st.r_pend | r_req) & ~r_rel;
  assign r_hands_over = (st.owner == OWN_RIGHT) & r_rel & (st.l_pend | l_req) & ~l_rel;
  assign tie_on_free  = (st.owner == OWN_NONE)  & l_req & r_req;

  assert_handover_left_R5: assert property (@(posedge clk) disable iff (rst)
    l_hands_over |=> (st.owner == OWN_RIGHT) && !st.r_pend);
  assert_handover_right_R5: assert property (@(posedge clk) disable iff (rst)
    r_hands_over |=> (st.owner == OWN_LEFT) && !st.l_pend);
  assert_deny_keeps_owner_R5: assert property (@(posedge clk) disable iff (rst)
    ((st.owner == OWN_LEFT) && !l_rel && r_req) |=> (st.owner == OWN_LEFT) && st.r_pend);
  assert_cancel_R6: assert property (@(posedge clk) disable iff (rst)
    ((st.owner == OWN_LEFT) && r_rel && !l_rel) |=> (st.owner == OWN_LEFT) && !st.r_pend);
  assert_tie_left_R8: assert property (@(posedge clk) disable iff (rst)
    tie_on_free |=> (st.owner == OWN_LEFT) && st.r_pend);
  assert_free_release_R10: assert property (@(posedge clk) disable iff (rst)
    ((st.owner == OWN_LEFT) && l_rel && !st.r_pend && !r_req) |=> (st.owner == OWN_NONE));
  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (st.owner == OWN_NONE) && !st.l_pend && !st.r_pend);
  assert_not_both_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (l_val | r_val));

endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
  parameter int NUM_TOK = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_TOK-1:0] vals,
  output logic [DATA_W-1:0]  rdata
);
  always_ff @(posedge clk) begin
    if (rst)       rdata <= '1;
    else if (fire) rdata <= {DATA_W{vals[idx]}};
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(rdata));
  assert_replicate_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> (rdata == '0) || (rdata == '1));

endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank #(
  parameter int NUM_TOK = 8,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_sem_sel,
  input  logic              l_mem_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_rd,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_sel,
  input  logic              r_mem_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_rd,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int IDX_W = $clog2(NUM_TOK);

  logic [IDX_W-1:0]   l_idx, r_idx;
  logic               l_wfire, r_wfire, l_wbit, r_wbit, l_rfire, r_rfire;
  logic [NUM_TOK-1:0] l_vals, r_vals;

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ldec (
    .sel(l_sem_sel), .mem_en(l_mem_en), .addr(l_addr), .wr(l_wr), .wdata(l_wdata),
    .rd(l_rd), .idx(l_idx), .wr_fire(l_wfire), .wr_bit(l_wbit), .rd_fire(l_rfire));

  sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdec (
    .sel(r_sem_sel), .mem_en(r_mem_en), .addr(r_addr), .wr(r_wr), .wdata(r_wdata),
    .rd(r_rd), .idx(r_idx), .wr_fire(r_wfire), .wr_bit(r_wbit), .rd_fire(r_rfire));

  for (genvar i = 0; i < NUM_TOK; i++) begin : g_tok
    logic l_hit, r_hit;
    assign l_hit = l_wfire & (l_idx == IDX_W'(i));
    assign r_hit = r_wfire & (r_idx == IDX_W'(i));
    sem_token_cell u_cell (
      .clk(clk), .rst(rst),
      .l_req(l_hit & ~l_wbit), .l_rel(l_hit & l_wbit),
      .r_req(r_hit & ~r_wbit), .r_rel(r_hit & r_wbit),
      .l_val(l_vals[i]), .r_val(r_vals[i]));
  end

  sem_read_reg #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_lrd (
    .clk(clk), .rst(rst), .fire(l_rfire), .idx(l_idx), .vals(l_vals), .rdata(l_rdata));

  sem_read_reg #(.NUM_TOK(NUM_TOK), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_rrd (
    .clk(clk), .rst(rst), .fire(r_rfire), .idx(r_idx), .vals(r_vals), .rdata(r_rdata));

endmodule

// File: tb/sim_sem_token_bank.sv
module sim_sem_token_bank;
  localparam int NUM_TOK = 8;
  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam logic [DATA_W-1:0] ONES = '1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              l_sem_sel, l_mem_en, l_wr, l_rd, r_sem_sel, r_mem_en, r_wr, r_rd;
  logic [ADDR_W-1:0] l_addr, r_addr;
  logic [DATA_W-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

  sem_token_bank #(.NUM_TOK(NUM_TOK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst(rst),
    .l_sem_sel(l_sem_sel), .l_mem_en(l_mem_en), .l_addr(l_addr), .l_wr(l_wr),
    .l_wdata(l_wdata), .l_rd(l_rd), .l_rdata(l_rdata),
    .r_sem_sel(r_sem_sel), .r_mem_en(r_mem_en), .r_addr(r_addr), .r_wr(r_wr),
    .r_wdata(r_wdata), .r_rd(r_rd), .r_rdata(r_rdata));

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model: holder 0 free, 1 left, 2 right; waiting flags.
  int own [NUM_TOK];
  bit lp  [NUM_TOK];
  bit rp  [NUM_TOK];

  bit l_sel_g = 1, l_mem_g = 0, r_sel_g = 1, r_mem_g = 0;
  logic [ADDR_W-4:0] l_hi = '0, r_hi = '0;

  typedef struct {
    int                due;
    bit                side_r;
    logic [DATA_W-1:0] exp;
    string             tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_val(input bit side_r, input int t);
    return (own[t] == (side_r ? 2 : 1)) ? '0 : ONES;
  endfunction

  function automatic void model_reset();
    for (int t = 0; t < NUM_TOK; t++) begin
      own[t] = 0; lp[t] = 0; rp[t] = 0;
    end
  endfunction

  function automatic void model_update(input bit lw, input bit lb, input int li,
                                       input bit rw, input bit rb, input int ri);
    for (int t = 0; t < NUM_TOK; t++) begin
      bit lq  = lw && (li == t) && !lb;
      bit lrl = lw && (li == t) &&  lb;
      bit rq  = rw && (ri == t) && !rb;
      bit rrl = rw && (ri == t) &&  rb;
      int o   = own[t];
      if (lrl && o != 1) lp[t] = 0;
      if (rrl && o != 2) rp[t] = 0;
      if (o == 0) begin
        if (lq) begin
          own[t] = 1;
          if (rq) rp[t] = 1;
        end else if (rq) own[t] = 2;
      end else if (o == 1) begin
        if (rq) rp[t] = 1;
        if (lrl) begin own[t] = rp[t] ? 2 : 0; rp[t] = 0; end
      end else begin
        if (lq) lp[t] = 1;
        if (rrl) begin own[t] = lp[t] ? 1 : 0; lp[t] = 0; end
      end
    end
  endfunction

  // Driver: called at a falling edge, runs one clock, returns at the next falling edge.
  task automatic step(input bit lw, input bit lb, input bit lr, input int li,
                      input bit rw, input bit rb, input bit rr, input int ri, input string tag);
    bit lok = l_sel_g && !l_mem_g;
    bit rok = r_sel_g && !r_mem_g;
    l_sem_sel = l_sel_g; l_mem_en = l_mem_g; r_sem_sel = r_sel_g; r_mem_en = r_mem_g;
    l_addr = {l_hi, li[2:0]}; r_addr = {r_hi, ri[2:0]};
    l_wdata = {{(DATA_W-1){~lb}}, lb}; r_wdata = {{(DATA_W-1){~rb}}, rb};
    l_wr = lw; l_rd = lr; r_wr = rw; r_rd = rr;
    if (lr && lok) sb.push_back('{cyc + 1, 1'b0, model_val(1'b0, li), tag});
    if (rr && rok) sb.push_back('{cyc + 1, 1'b1, model_val(1'b1, ri), tag});
    @(posedge clk);
    model_update(lw && lok, lb, li, rw && rok, rb, ri);
    @(negedge clk);
    l_wr = 0; l_rd = 0; r_wr = 0; r_rd = 0;
  endtask

  task automatic lwr(input int i, input bit b, input string tag); step(1, b, 0, i, 0, 0, 0, 0, tag); endtask
  task automatic rwr(input int i, input bit b, input string tag); step(0, 0, 0, 0, 1, b, 0, i, tag); endtask
  task automatic lrd(input int i, input string tag); step(0, 0, 1, i, 0, 0, 0, 0, tag); endtask
  task automatic rrd(input int i, input string tag); step(0, 0, 0, 0, 0, 0, 1, i, tag); endtask
  task automatic brd(input int i, input string tag); step(0, 0, 1, i, 0, 0, 1, i, tag); endtask

  // Monitor: pops expected read results on the falling edge they are due.
  always @(negedge clk) begin
    exp_t it;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      chk(it.side_r ? r_rdata : l_rdata, it.exp, it.tag);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    l_sem_sel = 1; l_mem_en = 0; l_addr = '0; l_wr = 0; l_wdata = '0; l_rd = 0;
    r_sem_sel = 1; r_mem_en = 0; r_addr = '0; r_wr = 0; r_wdata = '0; r_rd = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk(l_rdata, ONES, "R9 left read register after reset");
    chk(r_rdata, ONES, "R9 right read register after reset");
    for (int t = 0; t < NUM_TOK; t++) brd(t, "R9 token free after reset");

    // Basic request and read values, upper address bits varied.
    l_hi = 10'h3A5;
    lwr(3, 0, "R3 left request");
    brd(3, "R4 holder reads 0 other reads 1");
    l_hi = 10'h001;
    lrd(3, "R1 upper address bits ignored on read");
    l_hi = '0;

    // Refusal, stored request, handover.
    rwr(3, 0, "R5 right refused");
    rrd(3, "R5 refused right reads 1");
    lwr(3, 0, "R6 holder repeats request");
    lrd(3, "R6 holder unchanged after repeat");
    lwr(3, 1, "R5 release hands over");
    brd(3, "R5 right holds after handover");
    lwr(3, 0, "R6 left refused after handover");
    lrd(3, "R6 left still refused");
    rwr(3, 1, "R5 right release");
    brd(3, "R5 waiting left gains token");

    // Cancel of a stored request, then release frees.
    rwr(3, 0, "R6 right waits");
    rwr(3, 1, "R6 right cancels");
    lwr(3, 1, "R10 release without waiter");
    brd(3, "R6 cancel leaves token free");
    lwr(2, 0, "R10 left takes token 2");
    lwr(2, 1, "R10 left frees token 2");
    brd(2, "R10 token free after release");

    // Tie on a free token.
    step(1, 0, 0, 5, 1, 0, 0, 5, "R8 tie");
    brd(5, "R8 left wins tie");
    lwr(5, 1, "R8 left releases");
    brd(5, "R8 stored right request granted");
    rwr(5, 1, "R8 right releases");
    brd(5, "R8 token 5 free");

    // Access qualification.
    l_sel_g = 0;
    lwr(1, 0, "R2 write with select low");
    l_sel_g = 1; l_mem_g = 1;
    lwr(1, 0, "R2 write with memory enable high");
    l_mem_g = 0;
    r_sel_g = 0;
    rwr(1, 0, "R2 right write with select low");
    r_sel_g = 1;
    brd(1, "R2 ignored writes left token free");
    lwr(4, 0, "R2 left takes token 4");
    lrd(4, "R2 left reads held token 4");
    l_sel_g = 0;
    lrd(1, "R2 read with select low");
    chk(l_rdata, '0, "R2 read register unchanged by ignored read");
    l_sel_g = 1;
    r_mem_g = 1;
    rrd(4, "R2 right read blocked by memory enable");
    chk(r_rdata, ONES, "R2 right read register unchanged");
    r_mem_g = 0;

    // Read register snapshot.
    lwr(6, 0, "R7 left takes token 6");
    rwr(6, 0, "R7 right waits on token 6");
    rrd(6, "R7 right snapshot while refused");
    lwr(6, 1, "R7 left release after snapshot");
    chk(r_rdata, ONES, "R7 right value held after other port write");
    rrd(6, "R7 fresh read shows new holder");
    step(1, 0, 0, 7, 0, 0, 1, 7, "R7 read sees state before same-cycle write");
    lrd(7, "R7 left then holds token 7");

    // Index aliasing on the right port.
    r_hi = 10'h3FF;
    rwr(0, 0, "R1 right request with upper bits set");
    r_hi = 10'h155;
    brd(0, "R1 token 0 held by right");
    r_hi = '0;
    rwr(0, 1, "R1 right release");
    brd(0, "R1 token 0 free again");

    // Reset while tokens are held.
    rst = 1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
    chk(l_rdata, ONES, "R9 left read register after mid-run reset");
    chk(r_rdata, ONES, "R9 right read register after mid-run reset");
    for (int t = 0; t < NUM_TOK; t++) brd(t, "R9 token free after mid-run reset");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule